// File: doc/BRIEF.md
# UART Two-Stage Baud Tick Generator

This block derives the timing enables for a UART's transmitter and receiver from the reference clock. An optional fixed divide-by-8 stage comes first. When it is selected, it produces a one-cycle enable every eighth clock. It never produces a derived clock. A 16-bit sample divider counts those enables, or every clock when the prescaler is off, and issues a single-cycle sample enable once every CD counts. An 8-bit bit divider counts sample enables and issues a baud enable once every BDIV+1 of them. The resulting bit rate is the selected clock divided by CD × (BDIV + 1).

Software picks the three settings and presents them as static inputs. Any change to the prescaler select, CD or BDIV clears all counters. The first pulses after the change therefore follow the new values. A CD of 0 stops the sample enable. A CD of 1 passes the selected clock rate straight through. Useful settings are CD from 2 to 65535 and BDIV from 4 upward, but every encoding behaves as described.

Top module: `uart_baud_tickgen`

## Requirements
- R1: While rst_n is low, sample_en and baud_en are 0.
- R2: With pre_sel = 0 and CD ≥ 1, sample_en is a one-cycle pulse that is high exactly once every CD clock cycles.
- R3: With pre_sel = 1 and CD ≥ 1, sample_en is high exactly once every 8 × CD clock cycles, driven by a one-cycle enable from the divide-by-8 stage.
- R4: baud_en is high only in a cycle where sample_en is also high, and only on every (BDIV + 1)-th sample pulse.
- R5: With CD = 0, sample_en and baud_en stay 0.
- R6: With CD = 1 and pre_sel = 0, sample_en is high on every cycle once the setting is stable.
- R7: A change of pre_sel, cd_val or bdiv_val restarts all counters. Call E0 the first rising edge at which the new value is present, and let P be CD, or 8 × CD when pre_sel = 1. Then the first sample_en follows edge E0+P, the first baud_en follows edge E0+(BDIV+1)×P, and neither output is high right after E0.
- R8: The full 16-bit range of CD works: CD = 65535 gives one sample pulse per 65535 cycles.
- R9: The full 8-bit range of BDIV works: BDIV = 255 gives one baud pulse per 256 sample pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_sel | input | 1 | 1 selects the divide-by-8 prescale enable |
| cd_val | input | 16 | Sample divider (CD) |
| bdiv_val | input | 8 | Bit divider (BDIV); the baud period is BDIV+1 samples |
| sample_en | output | 1 | One-cycle sample-rate enable |
| baud_en | output | 1 | One-cycle bit-rate enable |

## Verification
Both outputs are registered. After a setting change first seen at edge E0, the output sampled after edge E0+k is due high when k is a positive multiple of the period. That period is P for sample_en and (BDIV+1)×P for baud_en, and the output is due low at every other k, including k = 0. The driver applies each setting at a falling edge and waits for E0. It then queues one expected pair per cycle for k = 0, 1, 2, and so on. The monitor compares one queued pair at every following falling edge, so each check lands midway between the edge that updates the outputs and the next one.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
   localparam int unsigned DEF_CD_W     = 16;
   localparam int unsigned DEF_BDIV_W   = 8;
   localparam int unsigned DEF_PRESCALE = 8;

   // Counter width needed to count 0 .. n-1 (at least 1 bit).
   function automatic int unsigned cnt_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale
   import baud_gen_pkg::*;
#(
   parameter int unsigned DIV = DEF_PRESCALE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic sel,
   output logic adv
);
   generate
      if (DIV > 1) begin : g_div
         localparam int unsigned PW = cnt_width(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pcnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             pcnt <= '0;
            else if (clr || !sel)   pcnt <= '0;
            else if (pcnt == LAST)  pcnt <= '0;
            else                    pcnt <= pcnt + 1'b1;
         end

         assign adv = !sel || (pcnt == LAST);
      end else begin : g_pass
         assign adv = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/baud_sample_div.sv
module baud_sample_div #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic [W-1:0] div,
   output logic         tick
);
   logic [W-1:0] scnt;
   logic         live;
   logic         at_end;

   assign live   = adv && (div != '0);
   assign at_end = (scnt == (div - 1'b1));
   assign tick   = live && at_end && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       scnt <= '0;
      else if (clr)     scnt <= '0;
      else if (live)    scnt <= at_end ? '0 : scnt + 1'b1;
   end
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic [W-1:0] div,
   output logic         tick
);
   logic [W-1:0] bcnt;
   logic         at_end;

   assign at_end = (bcnt == div);
   assign tick   = adv && at_end && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bcnt <= '0;
      else if (clr)   bcnt <= '0;
      else if (adv)   bcnt <= at_end ? '0 : bcnt + 1'b1;
   end
endmodule

// File: rtl/uart_baud_tickgen.sv
module uart_baud_tickgen
   import baud_gen_pkg::*;
#(
   parameter int unsigned CD_W     = DEF_CD_W,
   parameter int unsigned BDIV_W   = DEF_BDIV_W,
   parameter int unsigned PRESCALE = DEF_PRESCALE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pre_sel,
   input  logic [CD_W-1:0]   cd_val,
   input  logic [BDIV_W-1:0] bdiv_val,
   output logic              sample_en,
   output logic              baud_en
);
   generate
      if (CD_W < 2) begin : g_bad_cd
         $error("CD_W must be at least 2");
      end
      if (BDIV_W < 1) begin : g_bad_bdiv
         $error("BDIV_W must be at least 1");
      end
      if (PRESCALE < 1) begin : g_bad_pre
         $error("PRESCALE must be at least 1");
      end
   endgenerate

   logic [CD_W-1:0]   cd_q;
   logic [BDIV_W-1:0] bdiv_q;
   logic              sel_q;
   logic              restart;
   logic              pre_adv;
   logic              s_tick;
   logic              b_tick;

   assign restart = (cd_val != cd_q) || (bdiv_val != bdiv_q) || (pre_sel != sel_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cd_q   <= '0;
         bdiv_q <= '0;
         sel_q  <= 1'b0;
      end else if (restart) begin
         cd_q   <= cd_val;
         bdiv_q <= bdiv_val;
         sel_q  <= pre_sel;
      end
   end

   baud_prescale #(.DIV(PRESCALE)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .sel   (sel_q),
      .adv   (pre_adv)
   );

   baud_sample_div #(.W(CD_W)) u_smp (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .adv   (pre_adv),
      .div   (cd_q),
      .tick  (s_tick)
   );

   baud_bit_div #(.W(BDIV_W)) u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .adv   (s_tick),
      .div   (bdiv_q),
      .tick  (b_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_en <= 1'b0;
         baud_en   <= 1'b0;
      end else begin
         sample_en <= s_tick;
         baud_en   <= b_tick;
      end
   end
endmodule

// File: rtl/uart_baud_tickgen_chk.sv
module uart_baud_tickgen_chk #(
   parameter int unsigned CD_W   = 16,
   parameter int unsigned BDIV_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pre_sel,
   input logic [CD_W-1:0]   cd_val,
   input logic [BDIV_W-1:0] bdiv_val,
   input logic              sample_en,
   input logic              baud_en
);
   always_comb begin
      if (!rst_n) assert_quiet_in_reset_R1: assert (!sample_en && !baud_en);
   end

   assert_baud_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
      baud_en |-> sample_en);

   assert_cd_zero_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cd_val) == '0) |-> !sample_en);

   assert_cd_one_every_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(cd_val) == 1 && $past(cd_val, 2) == 1 &&
       !$past(pre_sel) && !$past(pre_sel, 2) &&
       $past(bdiv_val) == $past(bdiv_val, 2)) |-> sample_en);

   assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(cd_val) != $past(cd_val, 2)) |-> (!sample_en && !baud_en));
endmodule

bind uart_baud_tickgen uart_baud_tickgen_chk #(.CD_W(CD_W), .BDIV_W(BDIV_W)) u_chk (.*);

// File: tb/sim_uart_baud_tickgen.sv
`timescale 1ns/1ps
module sim_uart_baud_tickgen;
   typedef struct {
      bit    s;
      bit    b;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pre_sel = 1'b0;
   logic [15:0] cd_val = '0;
   logic [7:0]  bdiv_val = '0;
   logic        sample_en;
   logic        baud_en;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   uart_baud_tickgen u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .pre_sel   (pre_sel),
      .cd_val    (cd_val),
      .bdiv_val  (bdiv_val),
      .sample_en (sample_en),
      .baud_en   (baud_en)
   );

   // Apply a setting at a falling edge, wait for E0, queue expected pairs k = 0..n-1.
   task automatic run_cfg(input bit sel, input int cd, input int bd, input int n, input string tag);
      int p;
      @(negedge clk);
      pre_sel  = sel;
      cd_val   = 16'(cd);
      bdiv_val = 8'(bd);
      rst_n    = 1'b1;
      p = sel ? 8 * cd : cd;
      @(posedge clk);
      for (int k = 0; k < n; k++) begin
         exp_t e;
         e.s   = (cd != 0) && (k > 0) && (k % p == 0);
         e.b   = e.s && (k % ((bd + 1) * p) == 0);
         e.tag = tag;
         exp_q.push_back(e);
      end
      repeat (n - 1) @(negedge clk);
   endtask

   // Monitor: one comparison per falling edge.
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_chk++;
         if (sample_en !== e.s || baud_en !== e.b) begin
            n_bad++;
            $display("FAIL %s: sample/baud actual %b%b expected %b%b at %0t",
                     e.tag, sample_en, baud_en, e.s, e.b, $time);
         end
      end
   end

   initial begin
      pre_sel  = 1'b0;
      cd_val   = 16'd4;
      bdiv_val = 8'd3;
      // R1: outputs quiet while reset is held
      repeat (4) begin
         @(negedge clk);
         n_chk++;
         if (sample_en !== 1'b0 || baud_en !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: sample/baud actual %b%b expected 00", sample_en, baud_en);
         end
      end
      run_cfg(0, 4, 3, 60, "R2_R4");
      run_cfg(0, 4, 5, 40, "R7_bdiv_change");
      run_cfg(1, 3, 1, 120, "R3");
      run_cfg(1, 3, 2, 50, "R7_mid_restart");
      run_cfg(0, 0, 2, 40, "R5");
      run_cfg(0, 1, 4, 30, "R6");
      run_cfg(0, 2, 255, 1100, "R9");
      run_cfg(0, 65535, 0, 65600, "R8");
      run_cfg(1, 2, 4, 200, "R3_R4");
      run_cfg(0, 5, 0, 30, "R7_sel_change");
      @(negedge clk);
      wait (exp_q.size() == 0);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule